// File: doc/BRIEF.md
# Cascaded LCD Column Driver Chain

This block models the column side of a passive-matrix LCD half-panel as a chain of identical driver slices. Pixel data arrives eight bits at a time on a parallel bus, qualified by a shift enable that stands in for the panel shift clock. Each slice owns a fixed run of columns and fills them through eight parallel shift lanes. Only the slice holding an enable token takes bus words. When it has taken its share, the token moves on to the next slice, so one row is loaded from the leftmost column onward and the idle slices stay still.

A falling edge on the line-latch strobe copies every slice's shift contents into its holding latches and sends the token back to the first slice for the next row. The latched column bits are presented directly. A second registered copy is inverted whenever the frame-polarity input is high, so the column drive level can be flipped every frame and no DC bias builds up.

Top module: `lcd_col_chain`

## Requirements
- R1: After a synchronous reset, col_data, col_drive and row_full are all zero, and the first slice is ready to take the first word of a row.
- R2: Each accepted word carries eight column bits. Bit j of the k-th accepted word of a row (k counted from 0) ends up in column 8k+j, where column 0 is bit 0 of col_data. 240 words fill the 1920 columns, 30 words per slice.
- R3: At most one slice holds the token at a time. The token moves to the next slice right after a slice's 30th word, with no lost cycle. A cycle with shift_en low changes no slice.
- R4: Words presented after the 240th accepted word and before the next latch are ignored, and the latched row is unaffected.
- R5: col_data changes only on the clock edge that first samples latch_strobe low after it was high. It keeps its value through all shifting of the next row.
- R6: A latch event returns the token to the first slice and clears row_full. A shift_en pulse in the same cycle as the latch event is discarded.
- R7: col_drive equals col_data XOR polarity, registered one cycle later. A change of polarity inverts every drive bit and leaves col_data unchanged.
- R8: row_full is 0 while fewer than 240 words have been accepted since the last latch event. It is 1 from the edge that accepts the 240th word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Qualifies pix_in as one shift clock's worth of data |
| pix_in | input | 8 | Eight column bits, bit 0 for the lowest column |
| latch_strobe | input | 1 | Line latch; its falling edge transfers the row |
| polarity | input | 1 | Frame polarity; 1 inverts the drive levels |
| col_data | output | 1920 | Latched column bits, bit c for column c |
| col_drive | output | 1920 | Polarity-qualified column drive levels |
| row_full | output | 1 | All columns of the current row have been shifted in |

## Verification
The bench targets the slice hand-off. Rows are loaded with random idle gaps between words. An off-by-one in a slice's word count would shift every later slice's columns by eight and make the whole tail of the row mismatch. Extra words past the end of a row and a shift pulse in the latch cycle are both sent. A design that let either through would misalign or corrupt the next latched row. The latched outputs are sampled in the middle of the following row's load, and the polarity input is flipped with no new latch. These catch latches that follow the shift registers and drive levels that ignore the polarity or disturb col_data.

// File: rtl/lcd_chain_pkg.sv
package lcd_chain_pkg;

  // Number of shift clocks a slice needs to fill its columns.
  function automatic int slice_clocks(input int bits, input int lanes);
    return bits / lanes;
  endfunction

  // Counter width for a count running 0 .. n-1 (at least one bit).
  function automatic int count_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lcd_strobe_edge.sv
module lcd_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic fall_o
);

  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_i;
  end

  // High in the cycle where the strobe is first seen low after high.
  assign fall_o = strobe_q & ~strobe_i;

endmodule

// File: rtl/lcd_slice.sv
module lcd_slice
  import lcd_chain_pkg::*;
#(
  parameter int SLICE_BITS = 240,
  parameter int LANES      = 8,
  parameter bit IS_FIRST   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_i,
  input  logic [LANES-1:0]      pix_i,
  input  logic                  tok_in_i,
  input  logic                  latch_i,
  output logic                  tok_out_o,
  output logic                  active_o,
  output logic [SLICE_BITS-1:0] hold_o
);

  localparam int            DEPTH = slice_clocks(SLICE_BITS, LANES);
  localparam int            CW    = count_width(DEPTH);
  localparam logic [CW-1:0] LAST  = CW'(DEPTH - 1);

  logic                  active_q;
  logic [CW-1:0]         cnt_q;
  logic [SLICE_BITS-1:0] sr_q;
  logic [SLICE_BITS-1:0] hold_q;
  logic                  accept;

  // A word is taken only by the token holder, never in a latch cycle.
  assign accept    = active_q & shift_i & ~latch_i;
  assign tok_out_o = accept & (cnt_q == LAST);
  assign active_o  = active_q;
  assign hold_o    = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= IS_FIRST;
      cnt_q    <= '0;
      sr_q     <= '0;
      hold_q   <= '0;
    end else if (latch_i) begin
      hold_q   <= sr_q;
      active_q <= IS_FIRST;
      cnt_q    <= '0;
    end else if (accept) begin
      // Newest word enters at the top; after DEPTH words the first
      // word sits in the lowest lane group.
      sr_q <= {pix_i, sr_q[SLICE_BITS-1:LANES]};
      if (cnt_q == LAST) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (tok_in_i) begin
      active_q <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);                                             // R2
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !latch_i) |=> $stable(sr_q));                 // R3
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !latch_i |=> $stable(hold_q));                              // R5

endmodule

// File: rtl/lcd_drive_pol.sv
module lcd_drive_pol #(
  parameter int WIDTH = 1920
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pol_i,
  output logic [WIDTH-1:0] drive_o
);

  logic [WIDTH-1:0] drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= '0;
    else     drive_q <= data_i ^ {WIDTH{pol_i}};
  end

  assign drive_o = drive_q;

  // With steady data, a polarity flip must invert every drive bit.
  AST_POL_FLIP: assert property (@(posedge clk) disable iff (rst)
    ($stable(data_i) && $changed(pol_i)) |=> (drive_q == ~$past(drive_q))); // R7

endmodule

// File: rtl/lcd_col_chain.sv
module lcd_col_chain
  import lcd_chain_pkg::*;
#(
  parameter int NSLICE     = 8,
  parameter int SLICE_BITS = 240,
  parameter int LANES      = 8,
  parameter int ROW_BITS   = NSLICE * SLICE_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic [LANES-1:0]    pix_in,
  input  logic                latch_strobe,
  input  logic                polarity,
  output logic [ROW_BITS-1:0] col_data,
  output logic [ROW_BITS-1:0] col_drive,
  output logic                row_full
);

  logic              fire;
  logic [NSLICE:0]   tok;
  logic [NSLICE-1:0] active_vec;
  logic              row_full_q;

  lcd_strobe_edge i_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (latch_strobe),
    .fall_o   (fire)
  );

  assign tok[0] = 1'b0;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    lcd_slice #(
      .SLICE_BITS (SLICE_BITS),
      .LANES      (LANES),
      .IS_FIRST   (s == 0)
    ) i_slice (
      .clk       (clk),
      .rst       (rst),
      .shift_i   (shift_en),
      .pix_i     (pix_in),
      .tok_in_i  (tok[s]),
      .latch_i   (fire),
      .tok_out_o (tok[s+1]),
      .active_o  (active_vec[s]),
      .hold_o    (col_data[s*SLICE_BITS +: SLICE_BITS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || fire)     row_full_q <= 1'b0;
    else if (tok[NSLICE]) row_full_q <= 1'b1;
  end

  assign row_full = row_full_q;

  lcd_drive_pol #(.WIDTH(ROW_BITS)) i_pol (
    .clk     (clk),
    .rst     (rst),
    .data_i  (col_data),
    .pol_i   (polarity),
    .drive_o (col_drive)
  );

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active_vec));                                      // R3
  AST_TOKEN_HOME: assert property (@(posedge clk) disable iff (rst)
    fire |=> (active_vec == NSLICE'(1)));                       // R6
  AST_FULL_IDLE: assert property (@(posedge clk) disable iff (rst)
    row_full_q |-> (active_vec == '0));                         // R4

endmodule

// File: tb/test_lcd_col_chain.sv
module test_lcd_col_chain;

  localparam int ROW   = 1920;
  localparam int WORDS = 240;

  logic            clk = 1'b0;
  logic            rst;
  logic            shift_en;
  logic [7:0]      pix_in;
  logic            latch_strobe;
  logic            polarity;
  logic [ROW-1:0]  col_data;
  logic [ROW-1:0]  col_drive;
  logic            row_full;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  lcd_col_chain i_lcd_col_chain (
    .clk          (clk),
    .rst          (rst),
    .shift_en     (shift_en),
    .pix_in       (pix_in),
    .latch_strobe (latch_strobe),
    .polarity     (polarity),
    .col_data     (col_data),
    .col_drive    (col_drive),
    .row_full     (row_full)
  );

  task automatic chk_vec(input string req, input logic [ROW-1:0] act,
                         input logic [ROW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      for (int c = 0; c < ROW; c++) begin
        if (act[c] !== exp[c]) begin
          $display("FAIL %s column %0d actual %b expected %b", req, c, act[c], exp[c]);
          break;
        end
      end
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [ROW-1:0] rand_row();
    logic [ROW-1:0] r;
    for (int i = 0; i < ROW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // Send words [from, to) of a row; optional random idle cycles.
  task automatic send_words(input logic [ROW-1:0] row, input int from,
                            input int to, input bit gaps);
    for (int k = from; k < to; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        shift_en = 1'b0;
        pix_in   = 8'($urandom);
      end
      @(negedge clk);
      shift_en = 1'b1;
      pix_in   = row[k*8 +: 8];
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic do_latch(input bit junk_shift);
    @(negedge clk);
    latch_strobe = 1'b1;
    @(negedge clk);
    latch_strobe = 1'b0;
    shift_en     = junk_shift;
    pix_in       = 8'hA5;
    @(negedge clk);
    shift_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; shift_en = 1'b0; pix_in = '0; latch_strobe = 1'b0; polarity = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_vec("R1 col_data reset", col_data, '0);
    chk_vec("R1 col_drive reset", col_drive, '0);
    chk_bit("R1 row_full reset", row_full, 1'b0);
  endtask

  task automatic t_plain_row();
    logic [ROW-1:0] r = rand_row();
    send_words(r, 0, WORDS - 1, 1'b0);
    chk_bit("R8 row_full after 239 words", row_full, 1'b0);
    send_words(r, WORDS - 1, WORDS, 1'b0);
    chk_bit("R8 row_full after 240 words", row_full, 1'b1);
    chk_vec("R5 no update before latch", col_data, '0);
    do_latch(1'b0);
    chk_vec("R2 latched row", col_data, r);
    chk_vec("R7 drive at polarity 0", col_drive, r);
    chk_bit("R6 row_full cleared by latch", row_full, 1'b0);
  endtask

  task automatic t_gap_row();
    logic [ROW-1:0] r = rand_row();
    send_words(r, 0, WORDS, 1'b1);
    do_latch(1'b0);
    chk_vec("R3 row with idle gaps", col_data, r);
  endtask

  task automatic t_hold_and_extra();
    logic [ROW-1:0] a = rand_row();
    logic [ROW-1:0] b = rand_row();
    send_words(a, 0, WORDS, 1'b0);
    do_latch(1'b0);
    send_words(b, 0, 45, 1'b1);
    chk_vec("R5 held during next row (slice 1)", col_data, a);
    send_words(b, 45, 200, 1'b0);
    chk_vec("R5 held during next row (slice 6)", col_data, a);
    send_words(b, 200, WORDS, 1'b0);
    send_words(rand_row(), 0, 6, 1'b0);
    chk_vec("R4 extra words before latch", col_data, a);
    do_latch(1'b0);
    chk_vec("R4 extra words ignored", col_data, b);
  endtask

  task automatic t_latch_shift();
    logic [ROW-1:0] a = rand_row();
    logic [ROW-1:0] b = rand_row();
    send_words(a, 0, WORDS, 1'b0);
    do_latch(1'b1);
    chk_vec("R6 row before junk shift", col_data, a);
    send_words(b, 0, WORDS, 1'b0);
    chk_bit("R6 token restarted at slice 0", row_full, 1'b1);
    do_latch(1'b0);
    chk_vec("R6 shift in latch cycle discarded", col_data, b);
  endtask

  task automatic t_polarity();
    logic [ROW-1:0] r = rand_row();
    send_words(r, 0, WORDS, 1'b0);
    do_latch(1'b0);
    @(negedge clk);
    polarity = 1'b1;
    @(negedge clk);
    chk_vec("R7 drive inverted", col_drive, ~r);
    chk_vec("R7 data unchanged by polarity", col_data, r);
    polarity = 1'b0;
    @(negedge clk);
    chk_vec("R7 drive restored", col_drive, r);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_plain_row();
        t_gap_row();
        t_hold_and_extra();
        t_latch_shift();
        t_polarity();
      end
      begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule